// File: doc/BRIEF.md
# Single-Wire Bus Slave Bit Timing Engine

This block is the bit-level physical layer of a slave on an open-drain single-wire bus that idles high. It watches a bus input, cleans it with a two-flop synchronizer and a one-microsecond glitch filter, and times every event from the master's falling edge. A microsecond timebase is derived from a clock-frequency parameter, so all durations are given in microseconds and do not depend on the clock.

A long low level is taken as a bus reset. The block answers it with a presence pulse after a short wait. Short and long master lows inside a slot are decoded as received 1 and 0 bits. When the upper layer has selected a read slot, the block sends a bit that the upper layer supplies. It leaves the line alone for a 1 and holds it low past the master's sample point for a 0. The block drives the bus only through an active-low pull-down enable, so several slaves on one wire combine as a wired-AND. Upper layers see three one-cycle strobes: bit received, bit requested and reset seen.

Top module: `swire_slave_phy`

## Requirements
- R1: After the synchronous reset, `bus_drv_n` is 1 (bus released), all three strobes are 0 and `rx_bit` is 1.
- R2: With `rd_mode` low at the falling edge, a master low time below 15 µs yields one `rx_stb` pulse with `rx_bit` = 1, and a low time of 60 µs or more yields one `rx_stb` with `rx_bit` = 0. The line is sampled 30 µs (`SAMPLE_US`) after the filtered falling edge.
- R3: With `rd_mode` high at the falling edge, one `req_stb` pulse marks the slot start and `tx_bit` is taken. For `tx_bit` = 1 the bus is never pulled. For `tx_bit` = 0 `bus_drv_n` goes to 0 with the strobe and returns to 1 at `SAMPLE_US`, so the bus reads low 15 µs after the edge and high by 45 µs.
- R4: A low level lasting `RST_US` (480 µs) from the falling edge gives exactly one `rst_stb` pulse and aborts the slot in progress, with the bus released in that cycle.
- R5: After the rising edge that ends a reset, the block waits `PDH_US` (30 µs) and then pulls the bus low for `PDL_US` (120 µs). This is the presence pulse.
- R6: While `rst_block` is high, a long low is not a reset: no `rst_stb`, no presence pulse, and the slot simply ends when the line rises.
- R7: A low pulse shorter than one microsecond is ignored: no strobe of any kind follows it.
- R8: Every strobe lasts one clock cycle, and `rx_stb` and `rst_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of frequency `CLK_HZ` |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 1 | Asynchronous bus level |
| bus_drv_n | output | 1 | 0 pulls the bus low (open-drain enable) |
| rd_mode | input | 1 | 1: next slot is a read slot; 0: write slot |
| tx_bit | input | 1 | Bit sent in the next read slot |
| rst_block | input | 1 | 1: long lows are not treated as resets |
| rx_stb | output | 1 | One-cycle strobe: a bit was received |
| rx_bit | output | 1 | Last received bit |
| req_stb | output | 1 | One-cycle strobe: a read slot began and `tx_bit` was taken |
| rst_stb | output | 1 | One-cycle strobe: a bus reset was detected |

## Verification
Write slots use random low times on both sides of the decision window, plus directed lows at 2, 14, 60 and 110 µs. These show whether the sample point separates 1s from 0s. Read slots use random `tx_bit` and probe the wired bus at 15 and 50 µs after the edge, which shows both the stretched zero and its timely release. Resets come from idle, from inside a read-zero slot and under `rst_block`, which separates abort, presence timing and suppression. Sub-microsecond glitches in both modes must leave every strobe counter unchanged.

// File: rtl/swire_pkg.sv
package swire_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_RSTLOW,
    ST_PWAIT,
    ST_PDRV
  } phy_st_e;

  function automatic int unsigned cyc_per_us(input int unsigned hz);
    return (hz / 1_000_000 > 0) ? hz / 1_000_000 : 1;
  endfunction
endpackage

// File: rtl/swire_filt.sv
module swire_filt #(
  parameter int unsigned HOLD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic fall
);
  localparam int unsigned CW = (HOLD > 1) ? $clog2(HOLD) : 1;

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b11;
      lvl    <= 1'b1;
      cnt_q  <= '0;
      fall   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], din};
      fall   <= 1'b0;
      if (sync_q[1] == lvl) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(HOLD - 1)) begin
        cnt_q <= '0;
        lvl   <= sync_q[1];
        fall  <= lvl;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/swire_ustimer.sv
module swire_ustimer #(
  parameter int unsigned CYC = 4,
  parameter int unsigned UW  = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  output logic [UW-1:0] us
);
  localparam int unsigned PW = (CYC > 1) ? $clog2(CYC) : 1;

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre_q <= '0;
      us    <= '0;
    end else if (pre_q == PW'(CYC - 1)) begin
      pre_q <= '0;
      if (us != {UW{1'b1}}) us <= us + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/swire_phy_ctl.sv
module swire_phy_ctl
  import swire_pkg::*;
#(
  parameter int unsigned UW        = 10,
  parameter int unsigned SAMPLE_US = 30,
  parameter int unsigned RST_US    = 480,
  parameter int unsigned PDH_US    = 30,
  parameter int unsigned PDL_US    = 120
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lvl,
  input  logic          fall,
  input  logic [UW-1:0] us,
  input  logic          rd_mode,
  input  logic          tx_bit,
  input  logic          rst_block,
  output logic          tmr_clr,
  output logic          drv_n,
  output logic          rx_stb,
  output logic          rx_bit,
  output logic          req_stb,
  output logic          rst_stb
);
  phy_st_e st_q;
  logic    rd_q;
  logic    done_q;

  logic at_sample, at_rst, at_pdh, at_pdl;
  assign at_sample = (us >= UW'(SAMPLE_US));
  assign at_rst    = (us >= UW'(RST_US));
  assign at_pdh    = (us >= UW'(PDH_US));
  assign at_pdl    = (us >= UW'(PDL_US));

  always_comb begin
    tmr_clr = 1'b0;
    case (st_q)
      ST_IDLE:   tmr_clr = fall;
      ST_RSTLOW: tmr_clr = lvl;
      ST_PWAIT:  tmr_clr = at_pdh;
      default:   tmr_clr = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
      drv_n   <= 1'b1;
      rx_stb  <= 1'b0;
      rx_bit  <= 1'b1;
      req_stb <= 1'b0;
      rst_stb <= 1'b0;
    end else begin
      rx_stb  <= 1'b0;
      req_stb <= 1'b0;
      rst_stb <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (fall) begin
            st_q   <= ST_SLOT;
            done_q <= 1'b0;
            rd_q   <= rd_mode;
            if (rd_mode) begin
              req_stb <= 1'b1;
              drv_n   <= tx_bit;
            end
          end
        end
        ST_SLOT: begin
          if (!lvl && at_rst && !rst_block) begin
            st_q    <= ST_RSTLOW;
            drv_n   <= 1'b1;
            rst_stb <= 1'b1;
          end else if (!done_q && at_sample) begin
            done_q <= 1'b1;
            if (rd_q) begin
              drv_n <= 1'b1;
            end else begin
              rx_bit <= lvl;
              rx_stb <= 1'b1;
            end
          end else if (done_q && lvl) begin
            st_q <= ST_IDLE;
          end
        end
        ST_RSTLOW: begin
          if (lvl) st_q <= ST_PWAIT;
        end
        ST_PWAIT: begin
          if (at_pdh) begin
            drv_n <= 1'b0;
            st_q  <= ST_PDRV;
          end
        end
        ST_PDRV: begin
          if (at_pdl) begin
            drv_n <= 1'b1;
            st_q  <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swire_slave_phy.sv
module swire_slave_phy
  import swire_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned SAMPLE_US = 30,
  parameter int unsigned RST_US    = 480,
  parameter int unsigned PDH_US    = 30,
  parameter int unsigned PDL_US    = 120
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_in,
  output logic bus_drv_n,
  input  logic rd_mode,
  input  logic tx_bit,
  input  logic rst_block,
  output logic rx_stb,
  output logic rx_bit,
  output logic req_stb,
  output logic rst_stb
);
  localparam int unsigned CYC    = cyc_per_us(CLK_HZ);
  localparam int unsigned MAX_US = RST_US + PDL_US + SAMPLE_US + PDH_US;
  localparam int unsigned UW     = $clog2(MAX_US + 1);

  logic          lvl, fall, tmr_clr;
  logic [UW-1:0] us;

  swire_filt #(.HOLD(CYC)) filt_i (
    .clk (clk),
    .rst (rst),
    .din (bus_in),
    .lvl (lvl),
    .fall(fall)
  );

  swire_ustimer #(.CYC(CYC), .UW(UW)) tmr_i (
    .clk(clk),
    .rst(rst),
    .clr(tmr_clr),
    .us (us)
  );

  swire_phy_ctl #(
    .UW(UW), .SAMPLE_US(SAMPLE_US), .RST_US(RST_US),
    .PDH_US(PDH_US), .PDL_US(PDL_US)
  ) ctl_i (
    .clk      (clk),
    .rst      (rst),
    .lvl      (lvl),
    .fall     (fall),
    .us       (us),
    .rd_mode  (rd_mode),
    .tx_bit   (tx_bit),
    .rst_block(rst_block),
    .tmr_clr  (tmr_clr),
    .drv_n    (bus_drv_n),
    .rx_stb   (rx_stb),
    .rx_bit   (rx_bit),
    .req_stb  (req_stb),
    .rst_stb  (rst_stb)
  );
endmodule

// File: rtl/swire_slave_phy_chk.sv
module swire_slave_phy_chk (
  input logic clk,
  input logic rst,
  input logic rd_mode,
  input logic tx_bit,
  input logic rst_block,
  input logic bus_drv_n,
  input logic rx_stb,
  input logic req_stb,
  input logic rst_stb
);
  a_r8_rx_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rx_stb |=> !rx_stb);
  a_r8_rst_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rst_stb |=> !rst_stb);
  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rx_stb && rst_stb));
  a_r6_blocked: assert property (@(posedge clk) disable iff (rst)
    rst_stb |-> !$past(rst_block));
  a_r4_released: assert property (@(posedge clk) disable iff (rst)
    rst_stb |-> bus_drv_n);
  a_r3_req_mode: assert property (@(posedge clk) disable iff (rst)
    req_stb |-> $past(rd_mode));
  a_r3_drive_bit: assert property (@(posedge clk) disable iff (rst)
    req_stb |-> (bus_drv_n == $past(tx_bit)));
endmodule

bind swire_slave_phy swire_slave_phy_chk chk_i (
  .clk(clk), .rst(rst), .rd_mode(rd_mode), .tx_bit(tx_bit),
  .rst_block(rst_block), .bus_drv_n(bus_drv_n), .rx_stb(rx_stb),
  .req_stb(req_stb), .rst_stb(rst_stb)
);

// File: tb/swire_slave_phy_tb.sv
module swire_slave_phy_tb_top;
  localparam int unsigned CLK_HZ = 4_000_000;
  localparam int unsigned CYC    = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master_low = 1'b0;
  logic rd_mode = 1'b0, tx_bit = 1'b1, rst_block = 1'b0;
  logic bus_drv_n, rx_stb, rx_bit, req_stb, rst_stb;
  logic bus_in;

  assign bus_in = !master_low && bus_drv_n;

  always #2.5 clk = ~clk;

  swire_slave_phy #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk(clk), .rst(rst), .bus_in(bus_in), .bus_drv_n(bus_drv_n),
    .rd_mode(rd_mode), .tx_bit(tx_bit), .rst_block(rst_block),
    .rx_stb(rx_stb), .rx_bit(rx_bit), .req_stb(req_stb), .rst_stb(rst_stb)
  );

  int n_tests = 0, n_fail = 0;
  int n_rx = 0, n_req = 0, n_rst = 0;
  logic last_rx = 1'b1;
  bit finished = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_stb) begin n_rx++; last_rx = rx_bit; end
      if (req_stb) n_req++;
      if (rst_stb) n_rst++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_us(input int n);
    repeat (n * CYC) @(negedge clk);
  endtask

  function automatic bit exp_wr_bit(input int low_us);
    return (low_us < 15);
  endfunction

  // write slot with given low time, total slot length at least 80 us
  task automatic wr_slot(input int low_us);
    int rx0;
    rx0 = n_rx;
    rd_mode = 1'b0;
    master_low = 1'b1;
    wait_us(low_us);
    master_low = 1'b0;
    wait_us((low_us < 75) ? 80 - low_us : 5);
    check(n_rx == rx0 + 1, "R2 rx strobe count", n_rx - rx0, 1);
    check(last_rx == exp_wr_bit(low_us), "R2 rx bit", int'(last_rx), int'(exp_wr_bit(low_us)));
  endtask

  task automatic rd_slot(input bit b);
    int req0, rx0;
    req0 = n_req; rx0 = n_rx;
    rd_mode = 1'b1; tx_bit = b;
    master_low = 1'b1;
    wait_us(3);
    master_low = 1'b0;
    wait_us(12);
    check(bus_in == b, "R3 bus at 15us", int'(bus_in), int'(b));
    wait_us(35);
    check(bus_in == 1'b1, "R3 bus released by 50us", int'(bus_in), 1);
    wait_us(30);
    check(n_req == req0 + 1 && n_rx == rx0, "R3 one req strobe, no rx", n_req - req0, 1);
    rd_mode = 1'b0;
  endtask

  // long low; expect reset and presence unless blocked
  task automatic long_low(input bit blk, input bit rdm, input bit b);
    int rst0;
    rst0 = n_rst;
    rst_block = blk; rd_mode = rdm; tx_bit = b;
    master_low = 1'b1;
    wait_us(500);
    master_low = 1'b0;
    rd_mode = 1'b0;
    if (!blk) check(n_rst == rst0 + 1, "R4 one reset strobe", n_rst - rst0, 1);
    else      check(n_rst == rst0, "R6 blocked reset strobe", n_rst - rst0, 0);
    wait_us(10);
    check(bus_in == 1'b1, "R5 high before presence", int'(bus_in), 1);
    wait_us(70);
    if (!blk) check(bus_in == 1'b0, "R5 presence low at 80us", int'(bus_in), 0);
    else      check(bus_in == 1'b1, "R6 no presence at 80us", int'(bus_in), 1);
    wait_us(90);
    check(bus_in == 1'b1, "R5 presence ended by 170us", int'(bus_in), 1);
    wait_us(10);
    rst_block = 1'b0;
  endtask

  task automatic glitch(input bit rdm);
    int a0, b0, c0;
    a0 = n_rx; b0 = n_req; c0 = n_rst;
    rd_mode = rdm; tx_bit = 1'b0;
    master_low = 1'b1;
    repeat (CYC / 2) @(negedge clk);
    master_low = 1'b0;
    wait_us(80);
    check(n_rx == a0 && n_req == b0 && n_rst == c0, "R7 glitch ignored",
          (n_rx - a0) + (n_req - b0) + (n_rst - c0), 0);
    check(bus_in == 1'b1, "R7 bus idle after glitch", int'(bus_in), 1);
    rd_mode = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED1));
    repeat (10) @(negedge clk);
    check(bus_drv_n == 1'b1 && !rx_stb && !req_stb && !rst_stb, "R1 outputs at reset",
          int'({bus_drv_n, rx_stb, req_stb, rst_stb}), 8);
    check(rx_bit == 1'b1, "R1 rx_bit at reset", int'(rx_bit), 1);
    rst = 1'b0;
    wait_us(5);
    // directed write corners
    wr_slot(2); wr_slot(14); wr_slot(60); wr_slot(110);
    // random writes
    for (int i = 0; i < 60; i++) begin
      bit v;
      v = 1'($urandom % 2);
      wr_slot(v ? 2 + int'($urandom % 12) : 60 + int'($urandom % 50));
    end
    // read slots
    rd_slot(1'b0); rd_slot(1'b1);
    for (int i = 0; i < 40; i++) rd_slot(1'($urandom % 2));
    // resets
    long_low(1'b0, 1'b0, 1'b1);
    wr_slot(5);
    long_low(1'b0, 1'b1, 1'b0);   // R4 abort of a read-zero slot
    wr_slot(70);
    long_low(1'b1, 1'b0, 1'b1);   // R6 blocked
    wr_slot(8);
    // glitches
    glitch(1'b0);
    glitch(1'b1);
    wr_slot(90);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule